// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events for software profiling. It holds four 32-bit event counters and one 64-bit cycle counter. Each event counter has its own selector, which picks one bit of a wide pulse vector `evt_in`: the bit at index n is high in every cycle in which event n happens. The cycle counter counts clock cycles inside a window. A chosen start event opens the window and a chosen stop event closes it.

Software drives the block through a simple word-addressed register port. Writes take effect at the clock edge. Reads are combinational from the current state. Three pieces of per-counter state sit behind pairs of registers, one that sets bits and one that clears them: the counter enables, the overflow flags and the overflow interrupt enables. One bit layout serves all of these masks. A single level-sensitive interrupt line reports any flagged overflow whose interrupt is enabled.

Top module: `perf_mon`

## Requirements
- R1: Event counter i adds one in each cycle in which three conditions hold: control bit 0 (the global enable) is set, enable bit i is set, and the event bit chosen by its selector is high. It holds its value otherwise.
- R2: A write to control (offset 0) stores bit 0 as the global enable. A 1 in bit 1 zeroes all four event counters. A 1 in bit 2 zeroes the cycle counter. Bits 1 and 2 always read back as 0.
- R3: Each pair has a set register and a clear register. The pairs are enable (offsets 1 and 2), overflow (3 and 4) and interrupt enable (5 and 6). A 1 in the set register sets that bit and a 1 in the clear register clears it. A 0 in either leaves the bit unchanged. Reading the set register returns the state; reading the clear register returns 0.
- R4: In every mask, bits 0 to 3 stand for event counters 0 to 3 and bit 31 stands for the cycle counter. All other bits are ignored on write and read as 0.
- R5: Selectors sit at offsets 24 to 27, one per counter, and hold a 10-bit event number in bits [9:0]. The counter follows the `evt_in` bit at that index.
- R6: When a counter steps from all ones to zero, its overflow bit is set at that same clock edge. If software clears that bit in the same cycle, the set still wins.
- R7: The configuration word at offset 9 holds the start event number in bits [9:0] and the stop event number in bits [25:16]. The cycle counter counts while global enable and enable bit 31 are set. It starts counting in the cycle after the start event and stops in the cycle in which the stop event arrives; that cycle is not counted. If start and stop arrive in the same cycle, the stop wins.
- R8: `irq` is high exactly when some bit is set in both the overflow state and the interrupt-enable state.
- R9: Event counters can be written at offsets 16 to 19. The cycle counter can be written as its low word (offset 7) and its high word (offset 8). A software write takes priority over an increment in the same cycle.
- R10: After reset all state is zero, so every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_in | input | 1024 | Event pulses indexed by event number |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The hardest state to reach from the ports is a wrap, because each counter would need 2^32 or 2^64 increments to get there. The stimulus uses the direct-write path instead. It preloads the counters just below all ones and then sends a few selected events, which makes each wrap and the overflow flag it raises happen within a handful of cycles. This is done both in directed cases and in random runs that aim writes close to wrap. The start/stop window is hard to hit by chance, so the random phase limits selectors and window events to 16 event numbers. The same 16 numbers also carry the random pulses, which makes start, stop and the same-cycle collision of the two frequent.

// File: rtl/perf_mon.sv
module perf_mon #(
  parameter int EVT_W  = 10,
  parameter int NCNT   = 4,
  parameter int ADDR_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [(1<<EVT_W)-1:0]  evt_in,
  output logic                   irq
);

  localparam int A_CTRL = 0;
  localparam int A_ENS  = 1;
  localparam int A_ENC  = 2;
  localparam int A_OVS  = 3;
  localparam int A_OVC  = 4;
  localparam int A_IES  = 5;
  localparam int A_IEC  = 6;
  localparam int A_CCL  = 7;
  localparam int A_CCH  = 8;
  localparam int A_CFG  = 9;
  localparam int A_CNT  = 16;
  localparam int A_SEL  = 24;
  localparam int STOP_LSB = 16;

  logic             gen_en;
  logic [NCNT:0]    en_q, ov_q, ie_q;
  logic [31:0]      cnt_q [NCNT];
  logic [EVT_W-1:0] sel_q [NCNT];
  logic [63:0]      cc_q;
  logic             run_q;
  logic [EVT_W-1:0] start_q, stop_q;

  logic [NCNT:0]    wmask, wrap;
  logic [NCNT-1:0]  inc, wr_cnt;
  logic             evt_rst, cc_rst, wr_lo, wr_hi;
  logic             start_hit, stop_hit, cc_inc;

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int off);
    return bus_wr && (a == ADDR_W'(off));
  endfunction

  assign wmask   = {bus_wdata[31], bus_wdata[NCNT-1:0]};
  assign evt_rst = hit_addr(bus_addr, A_CTRL) && bus_wdata[1];
  assign cc_rst  = hit_addr(bus_addr, A_CTRL) && bus_wdata[2];
  assign wr_lo   = hit_addr(bus_addr, A_CCL);
  assign wr_hi   = hit_addr(bus_addr, A_CCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      en_q   <= '0;
      ov_q   <= '0;
      ie_q   <= '0;
    end else begin
      if (hit_addr(bus_addr, A_CTRL)) gen_en <= bus_wdata[0];
      if (hit_addr(bus_addr, A_ENS)) en_q <= en_q | wmask;
      else if (hit_addr(bus_addr, A_ENC)) en_q <= en_q & ~wmask;
      if (hit_addr(bus_addr, A_IES)) ie_q <= ie_q | wmask;
      else if (hit_addr(bus_addr, A_IEC)) ie_q <= ie_q & ~wmask;
      if (hit_addr(bus_addr, A_OVS)) ov_q <= ov_q | wmask | wrap;
      else if (hit_addr(bus_addr, A_OVC)) ov_q <= (ov_q & ~wmask) | wrap;
      else ov_q <= ov_q | wrap;
    end
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_evt
    assign inc[i]    = gen_en && en_q[i] && evt_in[sel_q[i]];
    assign wr_cnt[i] = hit_addr(bus_addr, A_CNT + i);
    assign wrap[i]   = inc[i] && (cnt_q[i] == 32'hFFFF_FFFF) && !evt_rst && !wr_cnt[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
        sel_q[i] <= '0;
      end else begin
        if (evt_rst) cnt_q[i] <= '0;
        else if (wr_cnt[i]) cnt_q[i] <= bus_wdata;
        else if (inc[i]) cnt_q[i] <= cnt_q[i] + 32'd1;
        if (hit_addr(bus_addr, A_SEL + i)) sel_q[i] <= bus_wdata[EVT_W-1:0];
      end
    end

    AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_rst || wr_cnt[i]) |=> (cnt_q[i] == $past(cnt_q[i]) || cnt_q[i] == $past(cnt_q[i]) + 32'd1))
      else $error("event counter jumped"); // R1
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[i] && cnt_q[i] == 32'hFFFF_FFFF && !evt_rst && !wr_cnt[i]) |=> (ov_q[i] && cnt_q[i] == 32'd0))
      else $error("wrap without overflow flag"); // R6
  end

  assign start_hit = evt_in[start_q];
  assign stop_hit  = evt_in[stop_q];
  assign cc_inc    = gen_en && en_q[NCNT] && run_q && !stop_hit;
  assign wrap[NCNT] = cc_inc && (cc_q == '1) && !cc_rst && !wr_lo && !wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q    <= '0;
      run_q   <= 1'b0;
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      if (stop_hit) run_q <= 1'b0;
      else if (start_hit) run_q <= 1'b1;
      if (cc_rst) cc_q <= '0;
      else if (wr_lo) cc_q[31:0] <= bus_wdata;
      else if (wr_hi) cc_q[63:32] <= bus_wdata;
      else if (cc_inc) cc_q <= cc_q + 64'd1;
      if (hit_addr(bus_addr, A_CFG)) begin
        start_q <= bus_wdata[EVT_W-1:0];
        stop_q  <= bus_wdata[STOP_LSB +: EVT_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL): bus_rdata[0] = gen_en;
      ADDR_W'(A_ENS):  bus_rdata = {en_q[NCNT], {(31-NCNT){1'b0}}, en_q[NCNT-1:0]};
      ADDR_W'(A_OVS):  bus_rdata = {ov_q[NCNT], {(31-NCNT){1'b0}}, ov_q[NCNT-1:0]};
      ADDR_W'(A_IES):  bus_rdata = {ie_q[NCNT], {(31-NCNT){1'b0}}, ie_q[NCNT-1:0]};
      ADDR_W'(A_CCL):  bus_rdata = cc_q[31:0];
      ADDR_W'(A_CCH):  bus_rdata = cc_q[63:32];
      ADDR_W'(A_CFG): begin
        bus_rdata[EVT_W-1:0]       = start_q;
        bus_rdata[STOP_LSB +: EVT_W] = stop_q;
      end
      default: ;
    endcase
    for (int i = 0; i < NCNT; i++) begin
      if (bus_addr == ADDR_W'(A_CNT + i)) bus_rdata = cnt_q[i];
      if (bus_addr == ADDR_W'(A_SEL + i)) bus_rdata = 32'(sel_q[i]);
    end
  end

  assign irq = |(ov_q & ie_q);

  AST_CTRL_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_CTRL)) |-> (bus_rdata[2:1] == 2'b00))
    else $error("reset bits read back set"); // R2
  AST_MASK_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_ENS) || bus_addr == ADDR_W'(A_OVS) || bus_addr == ADDR_W'(A_IES))
      |-> (bus_rdata[30:NCNT] == '0))
    else $error("reserved mask bit set"); // R4
  AST_CYC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !run_q)
    else $error("stop event did not close window"); // R7
  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cc_rst && !wr_lo && !wr_hi) |=> (cc_q == $past(cc_q)))
    else $error("cycle counter moved outside window"); // R7
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq ##1 irq) |-> (ov_q != $past(ov_q) || ie_q != $past(ie_q)))
    else $error("irq rose without state change"); // R8

endmodule

// File: tb/perf_mon_tb.sv
module perf_mon_tb;
  localparam int NE = 1024;
  localparam logic [31:0] MSK = 32'h8000_000F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NE-1:0] evt_in = '0;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  perf_mon u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
  );

  logic        m_gen, m_run;
  logic [31:0] m_en, m_ov, m_ie;
  logic [31:0] m_cnt [4];
  logic [9:0]  m_sel [4];
  logic [63:0] m_cc;
  logic [9:0]  m_start, m_stop;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    logic [31:0] r = '0;
    case (a)
      6'd0: r = {31'd0, m_gen};
      6'd1: r = m_en;
      6'd3: r = m_ov;
      6'd5: r = m_ie;
      6'd7: r = m_cc[31:0];
      6'd8: r = m_cc[63:32];
      6'd9: r = {6'd0, m_stop, 6'd0, m_start};
      6'd16, 6'd17, 6'd18, 6'd19: r = m_cnt[a-16];
      6'd24, 6'd25, 6'd26, 6'd27: r = {22'd0, m_sel[a-24]};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model(input logic w, input logic [5:0] a, input logic [31:0] d, input logic [NE-1:0] ev);
    logic [31:0] wov = '0;
    logic ss = ev[m_start];
    logic sp = ev[m_stop];
    logic cinc = m_gen && m_en[31] && m_run && !sp;
    logic [31:0] dm = d & MSK;
    for (int i = 0; i < 4; i++) begin
      logic inc = m_gen && m_en[i] && ev[m_sel[i]];
      if (w && a == 6'd0 && d[1]) m_cnt[i] = '0;
      else if (w && a == 6'(16 + i)) m_cnt[i] = d;
      else if (inc) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) wov[i] = 1'b1;
        m_cnt[i] = m_cnt[i] + 1;
      end
      if (w && a == 6'(24 + i)) m_sel[i] = d[9:0];
    end
    if (w && a == 6'd0 && d[2]) m_cc = '0;
    else if (w && a == 6'd7) m_cc[31:0] = d;
    else if (w && a == 6'd8) m_cc[63:32] = d;
    else if (cinc) begin
      if (m_cc == '1) wov[31] = 1'b1;
      m_cc = m_cc + 1;
    end
    m_run = sp ? 1'b0 : (ss ? 1'b1 : m_run);
    if (w && a == 6'd0) m_gen = d[0];
    if (w && a == 6'd1) m_en = m_en | dm;
    if (w && a == 6'd2) m_en = m_en & ~dm;
    if (w && a == 6'd5) m_ie = m_ie | dm;
    if (w && a == 6'd6) m_ie = m_ie & ~dm;
    if (w && a == 6'd3) m_ov = m_ov | dm;
    if (w && a == 6'd4) m_ov = m_ov & ~dm;
    m_ov = m_ov | wov;
    if (w && a == 6'd9) begin
      m_start = d[9:0];
      m_stop = d[25:16];
    end
  endtask

  task automatic step(input logic w, input logic [5:0] a, input logic [31:0] d, input logic [NE-1:0] ev);
    bus_wr = w; bus_addr = a; bus_wdata = d; evt_in = ev;
    model(w, a, d, ev);
    @(negedge clk);
    bus_wr = 1'b0; evt_in = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0);
  endtask

  task automatic pulse(input int n);
    logic [NE-1:0] ev = '0;
    ev[n] = 1'b1;
    step(1'b0, 6'd0, 32'd0, ev);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 6'd0, 32'd0, '0);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [5:0] addrs [18] = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9,
                               6'd16, 6'd17, 6'd18, 6'd19, 6'd24, 6'd25, 6'd26, 6'd27};
    v = $urandom(32'd1234);
    m_gen = 0; m_run = 0; m_en = 0; m_ov = 0; m_ie = 0; m_cc = 0; m_start = 0; m_stop = 0;
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_sel[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk_rd("R10 ctrl", 6'd0, 32'd0);
    chk_rd("R10 enable", 6'd1, 32'd0);
    chk_rd("R10 cnt0", 6'd16, 32'd0);
    chk_rd("R10 cyc lo", 6'd7, 32'd0);
    chk("R10 irq", {31'd0, irq}, 32'd0);

    // R3 R4 set/clear pairs and masks
    wr(6'd1, 32'hFFFF_FFFF);
    chk_rd("R4 enable mask", 6'd1, 32'h8000_000F);
    wr(6'd2, 32'h0000_0002);
    chk_rd("R3 enable clear", 6'd1, 32'h8000_000D);
    chk_rd("R3 clear reads zero", 6'd2, 32'd0);
    wr(6'd1, 32'h0000_0002);

    // R1 R5 counting through selectors
    wr(6'd24, 32'd5);
    wr(6'd25, 32'd7);
    wr(6'd0, 32'd1);
    pulse(5); pulse(5); pulse(5);
    chk_rd("R1 cnt0 counts", 6'd16, 32'd3);
    chk_rd("R5 cnt1 other event", 6'd17, 32'd0);
    chk_rd("R5 selector readback", 6'd24, 32'd5);
    wr(6'd0, 32'd0);
    pulse(5);
    chk_rd("R1 global enable off", 6'd16, 32'd3);
    wr(6'd0, 32'd1);

    // R6 R8 R9 wrap, overflow, interrupt
    wr(6'd16, 32'hFFFF_FFFE);
    chk_rd("R9 cnt write", 6'd16, 32'hFFFF_FFFE);
    pulse(5); pulse(5);
    chk_rd("R6 wrapped", 6'd16, 32'd0);
    chk_rd("R6 overflow flag", 6'd3, 32'h0000_0001);
    chk("R8 irq masked", {31'd0, irq}, 32'd0);
    wr(6'd5, 32'd1);
    chk("R8 irq raised", {31'd0, irq}, 32'd1);
    wr(6'd4, 32'd1);
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);

    // R2 reset bits
    pulse(5);
    wr(6'd0, 32'd3);
    chk_rd("R2 event reset", 6'd16, 32'd0);
    chk_rd("R2 self clear", 6'd0, 32'd1);

    // R7 cycle window
    wr(6'd0, 32'd5);
    wr(6'd9, (32'd9 << 16) | 32'd3);
    chk_rd("R7 cfg readback", 6'd9, 32'h0009_0003);
    pulse(3);
    idle(10);
    pulse(9);
    chk_rd("R7 window count", 6'd7, 32'd10);
    idle(5);
    chk_rd("R7 stopped", 6'd7, 32'd10);
    begin
      logic [NE-1:0] ev = '0;
      ev[3] = 1'b1; ev[9] = 1'b1;
      step(1'b0, 6'd0, 32'd0, ev);
    end
    idle(3);
    chk_rd("R7 stop priority", 6'd7, 32'd10);

    // R9 R6 64-bit write and wrap
    wr(6'd7, 32'hFFFF_FFFF);
    wr(6'd8, 32'hFFFF_FFFF);
    chk_rd("R9 cyc high write", 6'd8, 32'hFFFF_FFFF);
    pulse(3);
    idle(3);
    pulse(9);
    chk_rd("R6 cyc wrap lo", 6'd7, 32'd2);
    chk_rd("R6 cyc wrap hi", 6'd8, 32'd0);
    chk_rd("R6 cyc overflow", 6'd3, 32'h8000_0000);

    // random phase against the bench model
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] a = addrs[$urandom_range(17, 0)];
      logic [31:0] d = $urandom;
      logic w = ($urandom_range(3, 0) == 0);
      logic [NE-1:0] ev = '0;
      if (a == 6'd9 || (a >= 6'd24 && a <= 6'd27)) d = d & 32'h000F_000F;
      if (a == 6'd0 && $urandom_range(7, 0) != 0) d = d | 32'd1;
      if (((a >= 6'd16 && a <= 6'd19) || a == 6'd7 || a == 6'd8) && $urandom_range(1, 0) == 1)
        d = 32'hFFFF_FFF0 | (d & 32'hF);
      for (int k = 0; k < 3; k++)
        if ($urandom_range(1, 0) == 1) ev[$urandom_range(15, 0)] = 1'b1;
      step(w, a, d, ev);
      a = addrs[$urandom_range(17, 0)];
      rd(a, v);
      chk($sformatf("R3 R9 random read offset %0d", a), v, exp_rd(a));
      chk("R8 random irq", {31'd0, irq}, {31'd0, |(m_ov & m_ie)});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule